// File: doc/BRIEF.md
# Clock-Setting Watchdog with Safe-Code Fallback

This block protects a system against a hang caused by a bad clock setting. Software loads a down-count depth, in units of an external time-base tick of 250 ms, and then arms the timer. Each tick decrements the remaining count. If the count runs out before software re-arms or stops the timer, the block does four things. It asks the frequency logic to reload a frequency code. It clears the divider-override enable that it holds for the synthesizer. It raises a sticky timeout flag. If the shared pin is strapped for reset duty, it drives an active-low reset pulse.

The reload code comes from one of two places, chosen by a select bit: the latched strap code seen at the moment of expiry, or a 5-bit safe code programmed by software. Two 8-bit registers sit on a simple write port and a combinational read port. Several bits read back differently from what was written. The arm bit reads as "still counting". While the timer runs, the depth field reads the live remaining count.

Top module: `wdog_fallback`

## Requirements
- R1: After reset the control register (address 0) reads 0x02, the depth register (address 1) reads 0x08, `rst_n_o` is 1, `reload_req_o` and `mn_en_o` are 0.
- R2: Control register layout: bit 7 is arm (write 1 starts, write 0 stops; reads 1 only while counting), bit 6 is the read-only timeout flag, bit 5 selects the reload source, bits 4..0 are the safe code. Depth register layout: bit 7 is the divider-override enable (driven on `mn_en_o`), bits 6..0 are the depth.
- R3: While counting, each `tick_i` decrements the count, and a read of the depth field returns the remaining count. The timer expires on the tick that finds the count at 1 or 0, so a depth of D (D at least 1) expires on the D-th tick and a depth of 0 expires on the first tick. At expiry the arm bit reads 0 and the flag reads 1.
- R4: The cycle after the expiry edge, `reload_req_o` is high for exactly one cycle. `reload_code_o` then carries the safe code if the select bit is 1, or else `strap_code_i` as sampled at expiry. It holds that value until the next expiry.
- R5: Expiry clears the divider-override enable (`mn_en_o` and depth bit 7).
- R6: If `rst_mode_i` is 1 at expiry, `rst_n_o` goes low from the cycle after expiry until the next tick edge. If `rst_mode_i` is 0 there is no pulse. A further tick without a new expiry never lowers it again.
- R7: Writing arm = 0 stops the count. Later ticks cause no expiry, and the depth field reads the programmed depth.
- R8: Writing arm = 1, or writing the depth register while counting, reloads the count from the programmed or newly written depth and clears the timeout flag.
- R9: A register write in the same cycle as a tick takes priority: the count reloads and no expiry occurs.
- R10: Ticks while the timer is stopped change nothing visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe per 250 ms time-base period |
| strap_code_i | input | 5 | Frequency code latched from straps at power-up |
| rst_mode_i | input | 1 | 1 when the shared pin carries the reset output |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write address: 0 control, 1 depth |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 1 | Read address: 0 control, 1 depth |
| rd_data_o | output | 8 | Combinational read data |
| reload_req_o | output | 1 | One-cycle frequency reload request |
| reload_code_o | output | 5 | Code to reload, held between expiries |
| mn_en_o | output | 1 | Divider-override enable, cleared on expiry |
| rst_n_o | output | 1 | Active-low reset pulse output |

## Verification
A wrong remaining count shows on the depth read port after the very next tick, and it shifts the expiry by one or more ticks, which the reload strobe exposes right away. A flag or arm-state error shows on the control read port in the cycle after the write or tick that caused it. A wrong reload source, a missed override clear or a mis-timed reset pulse appears in the single cycle that follows the expiry edge, or at the next tick for the pulse release. Random depths, select settings and strap codes are mixed with directed cases: zero depth, a stop, a reload in mid-count, and a write colliding with a tick.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // register selector for both read and write ports
   typedef enum logic [0:0] {
      WD_REG_CTRL  = 1'b0,
      WD_REG_DEPTH = 1'b1
   } wd_reg_e;

   // control-register bit offsets counted down from the top of the byte
   localparam int unsigned WD_ARM_OFS  = 1;
   localparam int unsigned WD_FLAG_OFS = 2;
   localparam int unsigned WD_SEL_OFS  = 3;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned DEPTH_W   = 7,
   parameter int unsigned CODE_W    = 5,
   parameter int unsigned DEPTH_RST = 8,
   parameter int unsigned SAFE_RST  = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic               expire,
   output logic [DEPTH_W-1:0] depth_q,
   output logic               safe_sel_q,
   output logic [CODE_W-1:0]  safe_code_q,
   output logic               mn_en_q,
   output logic               arm_set,
   output logic               arm_clr,
   output logic               depth_wr
);
   localparam int unsigned ARM_B = DATA_W - WD_ARM_OFS;
   localparam int unsigned SEL_B = DATA_W - WD_SEL_OFS;
   localparam int unsigned MN_B  = DATA_W - 1;

   logic ctrl_wr;

   always_comb begin
      ctrl_wr  = wr_en && (wr_addr == WD_REG_CTRL);
      depth_wr = wr_en && (wr_addr == WD_REG_DEPTH);
      arm_set  = ctrl_wr && wr_data[ARM_B];
      arm_clr  = ctrl_wr && !wr_data[ARM_B];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         depth_q     <= DEPTH_W'(DEPTH_RST);
         safe_sel_q  <= 1'b0;
         safe_code_q <= CODE_W'(SAFE_RST);
         mn_en_q     <= 1'b0;
      end else begin
         if (ctrl_wr) begin
            safe_sel_q  <= wr_data[SEL_B];
            safe_code_q <= wr_data[CODE_W-1:0];
         end
         if (depth_wr) begin
            depth_q <= wr_data[DEPTH_W-1:0];
            mn_en_q <= wr_data[MN_B];
         end else if (expire) begin
            mn_en_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned DEPTH_W = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               arm_set,
   input  logic               arm_clr,
   input  logic               depth_wr,
   input  logic [DEPTH_W-1:0] depth_q,
   input  logic [DEPTH_W-1:0] wr_depth,
   output logic               run_q,
   output logic [DEPTH_W-1:0] cnt_q,
   output logic               flag_q,
   output logic               expire
);
   localparam logic [DEPTH_W-1:0] ONE = DEPTH_W'(1);

   logic               load;
   logic [DEPTH_W-1:0] load_val;

   always_comb begin
      load     = arm_set || (depth_wr && run_q);
      load_val = depth_wr ? wr_depth : depth_q;
      expire   = tick && run_q && !load && !arm_clr && (cnt_q <= ONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         flag_q <= 1'b0;
      end else if (arm_clr) begin
         run_q <= 1'b0;
      end else if (load) begin
         run_q  <= 1'b1;
         cnt_q  <= load_val;
         flag_q <= 1'b0;
      end else if (expire) begin
         run_q  <= 1'b0;
         cnt_q  <= '0;
         flag_q <= 1'b1;
      end else if (tick && run_q) begin
         cnt_q <= cnt_q - ONE;
      end
   end
endmodule

// File: rtl/wdog_rstpulse.sv
module wdog_rstpulse #(
   parameter int unsigned PULSE_TICKS = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic fire,
   output logic rst_n_o
);
   generate
      if (PULSE_TICKS == 1) begin : g_single
         logic low_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     low_q <= 1'b0;
            else if (fire)  low_q <= 1'b1;
            else if (tick)  low_q <= 1'b0;
         end
         assign rst_n_o = !low_q;
      end else begin : g_multi
         localparam int unsigned PW = $clog2(PULSE_TICKS + 1);
         logic [PW-1:0] left_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      left_q <= '0;
            else if (fire)                   left_q <= PW'(PULSE_TICKS);
            else if (tick && left_q != '0)   left_q <= left_q - PW'(1);
         end
         assign rst_n_o = (left_q == '0);
      end
   endgenerate
endmodule

// File: rtl/wdog_fallback.sv
module wdog_fallback
   import wdog_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH_W     = 7,
   parameter int unsigned CODE_W      = 5,
   parameter int unsigned DEPTH_RST   = 8,
   parameter int unsigned SAFE_RST    = 2,
   parameter int unsigned PULSE_TICKS = 1,
   parameter bit          LIVE_READ   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [CODE_W-1:0] strap_code_i,
   input  logic              rst_mode_i,
   input  logic              wr_en_i,
   input  logic              wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              reload_req_o,
   output logic [CODE_W-1:0] reload_code_o,
   output logic              mn_en_o,
   output logic              rst_n_o
);
   localparam int unsigned ARM_B  = DATA_W - WD_ARM_OFS;
   localparam int unsigned FLAG_B = DATA_W - WD_FLAG_OFS;
   localparam int unsigned SEL_B  = DATA_W - WD_SEL_OFS;
   localparam int unsigned MN_B   = DATA_W - 1;

   // elaboration-time parameter checks
   generate
      if (CODE_W + WD_SEL_OFS > DATA_W) begin : g_bad_code
         $error("safe code does not fit below the control bits");
      end
      if (DEPTH_W + 1 > DATA_W) begin : g_bad_depth
         $error("depth field does not fit below the override bit");
      end
      if (DEPTH_RST >= (1 << DEPTH_W)) begin : g_bad_drst
         $error("depth reset value exceeds field width");
      end
      if (SAFE_RST >= (1 << CODE_W)) begin : g_bad_srst
         $error("safe code reset value exceeds field width");
      end
      if (PULSE_TICKS < 1) begin : g_bad_pulse
         $error("reset pulse must last at least one tick");
      end
   endgenerate

   logic [DEPTH_W-1:0] depth_q;
   logic               safe_sel_q;
   logic [CODE_W-1:0]  safe_code_q;
   logic               mn_en_q;
   logic               arm_set, arm_clr, depth_wr;
   logic               run_q, flag_q, expire;
   logic [DEPTH_W-1:0] cnt_q;
   logic               req_q;
   logic [CODE_W-1:0]  code_q;

   wdog_regs #(
      .DATA_W(DATA_W), .DEPTH_W(DEPTH_W), .CODE_W(CODE_W),
      .DEPTH_RST(DEPTH_RST), .SAFE_RST(SAFE_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en_i), .wr_addr(wr_addr_i), .wr_data(wr_data_i),
      .expire(expire),
      .depth_q(depth_q), .safe_sel_q(safe_sel_q), .safe_code_q(safe_code_q),
      .mn_en_q(mn_en_q), .arm_set(arm_set), .arm_clr(arm_clr), .depth_wr(depth_wr)
   );

   wdog_counter #(.DEPTH_W(DEPTH_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_i),
      .arm_set(arm_set), .arm_clr(arm_clr), .depth_wr(depth_wr),
      .depth_q(depth_q), .wr_depth(wr_data_i[DEPTH_W-1:0]),
      .run_q(run_q), .cnt_q(cnt_q), .flag_q(flag_q), .expire(expire)
   );

   wdog_rstpulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
      .clk(clk), .rst_n(rst_n), .tick(tick_i),
      .fire(expire && rst_mode_i), .rst_n_o(rst_n_o)
   );

   // reload request and code, registered at expiry
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         code_q <= '0;
      end else begin
         req_q <= expire;
         if (expire) code_q <= safe_sel_q ? safe_code_q : strap_code_i;
      end
   end

   // depth readback variant
   logic [DEPTH_W-1:0] depth_view;
   generate
      if (LIVE_READ) begin : g_live
         assign depth_view = run_q ? cnt_q : depth_q;
      end else begin : g_static
         assign depth_view = depth_q;
      end
   endgenerate

   always_comb begin
      rd_data_o = '0;
      if (rd_addr_i == WD_REG_CTRL) begin
         rd_data_o[ARM_B]        = run_q;
         rd_data_o[FLAG_B]       = flag_q;
         rd_data_o[SEL_B]        = safe_sel_q;
         rd_data_o[CODE_W-1:0]   = safe_code_q;
      end else begin
         rd_data_o[MN_B]         = mn_en_q;
         rd_data_o[DEPTH_W-1:0]  = depth_view;
      end
   end

   assign reload_req_o  = req_q;
   assign reload_code_o = code_q;
   assign mn_en_o       = mn_en_q;
endmodule

// File: rtl/wdog_fallback_chk.sv
module wdog_fallback_chk #(
   parameter int unsigned DEPTH_W = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick_i,
   input logic               wr_en_i,
   input logic               reload_req_o,
   input logic               rst_n_o,
   input logic               mn_en_o,
   input logic               run_q,
   input logic               flag_q,
   input logic [DEPTH_W-1:0] cnt_q
);
   p_cnt_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick_i && !wr_en_i && cnt_q > DEPTH_W'(1))
      |=> (run_q && cnt_q == $past(cnt_q) - DEPTH_W'(1)));

   p_req_state_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req_o |-> (flag_q && !run_q));

   p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req_o |=> !reload_req_o);

   p_mn_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reload_req_o |-> !mn_en_o);

   p_rst_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rst_n_o) |-> reload_req_o);

   p_rst_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_n_o && !tick_i) |=> !rst_n_o);

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !wr_en_i) |=> (!run_q && $stable(flag_q) && !reload_req_o));
endmodule

bind wdog_fallback wdog_fallback_chk #(.DEPTH_W(DEPTH_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
   .reload_req_o(reload_req_o), .rst_n_o(rst_n_o), .mn_en_o(mn_en_o),
   .run_q(run_q), .flag_q(flag_q), .cnt_q(cnt_q)
);

// File: tb/wdog_fallback_bench.sv
module wdog_fallback_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic [4:0] strap_code_i = 5'h00;
   logic       rst_mode_i = 1'b0;
   logic       wr_en_i = 1'b0;
   logic       wr_addr_i = 1'b0;
   logic [7:0] wr_data_i = 8'h00;
   logic       rd_addr_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       reload_req_o;
   logic [4:0] reload_code_o;
   logic       mn_en_o;
   logic       rst_n_o;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   wdog_fallback u_wdog_fallback (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .strap_code_i(strap_code_i),
      .rst_mode_i(rst_mode_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
      .reload_req_o(reload_req_o), .reload_code_o(reload_code_o),
      .mn_en_o(mn_en_o), .rst_n_o(rst_n_o)
   );

   function automatic logic [7:0] ctrl_val(input bit run, input bit flg,
                                           input bit sel, input logic [4:0] code);
      return {run, flg, sel, code};
   endfunction

   function automatic logic [4:0] exp_code(input bit sel, input logic [4:0] safe,
                                           input logic [4:0] strap);
      return sel ? safe : strap;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
      cyc();
      wr_en_i = 1'b0;
   endtask

   task automatic tk();
      tick_i = 1'b1;
      cyc();
      tick_i = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      rd_addr_i = a;
      #1;
      d = rd_data_o;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      void'($urandom(32'd4711));
      repeat (3) cyc();
      rst_n = 1'b1;
      cyc();

      // R1 reset state
      rd(1'b0, v); chk("R1 ctrl", v, 8'h02);
      rd(1'b1, v); chk("R1 depth", v, 8'h08);
      chk("R1 rst_n_o", rst_n_o, 1);
      chk("R1 req", reload_req_o, 0);
      chk("R1 mn_en", mn_en_o, 0);

      // R10 idle ticks
      tk(); tk(); tk();
      rd(1'b0, v); chk("R10 ctrl idle", v, 8'h02);
      chk("R10 req idle", reload_req_o, 0);

      // R2/R3/R4/R5/R6 directed: depth 3, strap source, reset mode
      wr(1'b1, 8'h83);
      chk("R2 mn_en set", mn_en_o, 1);
      rd(1'b1, v); chk("R2 depth prog", v, 8'h83);
      wr(1'b0, 8'h82);
      rd(1'b0, v); chk("R2 ctrl running", v, ctrl_val(1, 0, 0, 5'h02));
      rd(1'b1, v); chk("R3 live count 3", v, 8'h83);
      tk(); rd(1'b1, v); chk("R3 live count 2", v, 8'h82);
      tk(); rd(1'b1, v); chk("R3 live count 1", v, 8'h81);
      chk("R3 no early req", reload_req_o, 0);
      strap_code_i = 5'h15; rst_mode_i = 1'b1;
      tk();
      chk("R4 req pulse", reload_req_o, 1);
      chk("R4 strap code", reload_code_o, 5'h15);
      rd(1'b0, v); chk("R3 flag set", v, ctrl_val(0, 1, 0, 5'h02));
      rd(1'b1, v); chk("R5 depth after expiry", v, 8'h03);
      chk("R5 mn_en cleared", mn_en_o, 0);
      chk("R6 rst low", rst_n_o, 0);
      strap_code_i = 5'h01;
      cyc();
      chk("R4 req one cycle", reload_req_o, 0);
      chk("R4 code held", reload_code_o, 5'h15);
      repeat (3) cyc();
      chk("R6 rst held", rst_n_o, 0);
      tk(); chk("R6 rst released", rst_n_o, 1);
      tk(); chk("R6 no retrigger", rst_n_o, 1);

      // R8 arm clears flag, R7 stop
      wr(1'b0, 8'hA7);
      rd(1'b0, v); chk("R8 flag cleared by arm", v, ctrl_val(1, 0, 1, 5'h07));
      tk();
      wr(1'b0, 8'h27);
      tk(); tk(); tk(); tk();
      chk("R7 no req after stop", reload_req_o, 0);
      rd(1'b0, v); chk("R7 ctrl stopped", v, ctrl_val(0, 0, 1, 5'h07));
      rd(1'b1, v); chk("R7 depth shows programmed", v, 8'h03);

      // R8 depth rewrite reloads; R6 no pulse when not in reset mode
      rst_mode_i = 1'b0;
      wr(1'b0, 8'hA9);
      tk(); tk();
      rd(1'b1, v); chk("R8 count before rewrite", v, 8'h01);
      wr(1'b1, 8'h04);
      rd(1'b1, v); chk("R8 count reloaded", v, 8'h04);
      tk(); tk(); tk();
      chk("R8 no req yet", reload_req_o, 0);
      tk();
      chk("R8 req after reload", reload_req_o, 1);
      chk("R4 safe code", reload_code_o, 5'h09);
      chk("R6 no pulse in clock mode", rst_n_o, 1);

      // R9 write collides with tick
      wr(1'b0, 8'hA9);
      tk(); tk(); tk();
      tick_i = 1'b1; wr_en_i = 1'b1; wr_addr_i = 1'b0; wr_data_i = 8'hA9;
      cyc();
      tick_i = 1'b0; wr_en_i = 1'b0;
      chk("R9 no expiry on collision", reload_req_o, 0);
      rd(1'b1, v); chk("R9 count reloaded", v, 8'h04);
      wr(1'b0, 8'h29);

      // R3 depth 0 and depth 1 expire on the first tick
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h80);
      tk(); chk("R3 depth0 first tick", reload_req_o, 1);
      wr(1'b1, 8'h01);
      wr(1'b0, 8'h80);
      tk(); chk("R3 depth1 first tick", reload_req_o, 1);

      // randomized runs
      for (int it = 0; it < 24; it++) begin
         int unsigned d = 1 + ($urandom % 6);
         bit sel = 1'($urandom);
         bit md = 1'($urandom);
         logic [4:0] sf = 5'($urandom);
         logic [4:0] st = 5'($urandom);
         strap_code_i = st; rst_mode_i = md;
         wr(1'b1, {1'b1, 7'(d)});
         wr(1'b0, ctrl_val(1, 0, sel, sf));
         for (int k = 1; k < int'(d); k++) begin
            tk();
            rd(1'b1, v); chk("R3 random count", v, {1'b1, 7'(d - k)});
            chk("R3 random no early req", reload_req_o, 0);
         end
         tk();
         chk("R4 random req", reload_req_o, 1);
         chk("R4 random code", reload_code_o, exp_code(sel, sf, st));
         rd(1'b0, v); chk("R3 random ctrl", v, ctrl_val(0, 1, sel, sf));
         chk("R5 random mn clear", mn_en_o, 0);
         chk("R6 random rst", rst_n_o, !md);
         tk();
         chk("R6 random release", rst_n_o, 1);
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule